// File: doc/BRIEF.md
# Cell-Bus Transmit Slave with Cell-Available Flow Control

This block is the PHY-side receiver of a byte-wide ATM cell transmit bus. An ATM-layer master writes bytes into it with an active-low write strobe, and marks the first byte of each 53-byte cell with a start-of-cell flag. The bytes go into a four-cell FIFO. The framer side drains that FIFO through a simple read port. Only whole cells are visible on the read port. A cell that is still being assembled stays hidden until its last byte arrives, and it is thrown away if a new start-of-cell cuts it short.

A cell-available output paces the master. In octet mode it reports whether four more writes fit. In cell mode it reports whether a whole further cell fits. In multi-PHY mode, a select state machine watches the 5-bit address bus and compares it with a programmed own address. Cell-available is enabled only in the cycle that follows a matching address sampled with the write strobe low. While enabled, it follows the cell rule.

Two state machines carry the control. The assembly machine has the states ASM_IDLE (no partial cell) and ASM_FILL (a partial cell is pending). Its transitions are: ASM_IDLE→ASM_FILL on an accepted byte; ASM_FILL→ASM_FILL on an accepted byte that does not complete the cell, or on a runt restart; ASM_FILL→ASM_IDLE on the 53rd byte, which commits the cell. The select machine has the states SEL_OFF and SEL_ON. It moves to SEL_ON after any edge with a valid match, and back to SEL_OFF after any edge without one.

Top module: `cell_tx_slave`

## Requirements
- R1: After reset the FIFO is empty, `cell_ready`, `overflow` and `runt_err` are 0, and the select state is SEL_OFF (in multi-PHY mode `clav_oe` is 0).
- R2: Each rising edge with `wr_n` low and fewer than 212 bytes held stores `din`. Committed bytes come out on `rd_data` in write order, and `rd_data` always shows the oldest committed byte.
- R3: With `mode` = 2'b00 (octet), `clav` is 1 exactly when the free space (212 minus the bytes held, partial cell included) is at least 4.
- R4: With `mode` = 2'b01 (cell), `clav` is 1 exactly when the free space is at least 53.
- R5: With `mode` = 2'b10 (multi-PHY), `clav_oe` is 1 in the cycle after an edge that sampled `addr` == `own_addr` with `wr_n` low. It is 0 in the cycle after any other edge. While `clav_oe` is 1, `clav` follows the R4 rule. While `clav_oe` is 0, `clav` is 0.
- R6: In every mode other than 2'b10, `clav_oe` is 1 and `addr` has no effect on any output.
- R7: A write while 212 bytes are held is ignored and leaves stored data intact. The same edge sets `overflow`, which stays 1 until reset.
- R8: An accepted byte with `soc` high while 1 to 52 bytes of a cell are pending discards those pending bytes and sets the sticky `runt_err`. That byte then becomes byte 0 of a new cell.
- R9: `cell_ready` is 1 exactly when at least 53 committed bytes are held. `rd_en` removes one committed byte per edge. `rd_en` with no committed byte has no effect, and partial-cell bytes are never readable.
- R10: `mode` = 2'b11 behaves as cell mode (R4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Cell byte from the master |
| wr_n | input | 1 | Active-low write strobe |
| soc | input | 1 | Marks the first byte of a cell |
| addr | input | 5 | Multi-PHY address bus |
| own_addr | input | 5 | Programmed own address |
| mode | input | 2 | 00 octet, 01 cell, 10 multi-PHY, 11 cell |
| clav | output | 1 | Cell-available flow control |
| clav_oe | output | 1 | Output enable for `clav` (0 = high impedance) |
| rd_en | input | 1 | Framer-side read strobe |
| rd_data | output | 8 | Oldest committed byte |
| cell_ready | output | 1 | At least one whole cell is readable |
| overflow | output | 1 | Sticky: write refused while full |
| runt_err | output | 1 | Sticky: partial cell discarded |

## Verification
The first pattern writes whole cells back to back and drains them with the octet threshold active. This separates correct ordering and commit timing from off-by-one errors in the fill count. Filling past 212 bytes, then draining, shows whether refused writes leave the stored data and the count untouched. Runt sequences interleaved with full cells in cell mode show whether a discard rolls the write position back to the last committed byte. Address sweeps in multi-PHY mode, with the strobe both high and low, tell a match that is one cycle late or ignores the strobe apart from a correct one. Random strobes and addresses in the other modes show that the address is ignored there.

// File: rtl/cbtx_pkg.sv
package cbtx_pkg;

    typedef enum logic [1:0] {
        MODE_OCTET = 2'b00,
        MODE_CELL  = 2'b01,
        MODE_MPHY  = 2'b10,
        MODE_CELL2 = 2'b11
    } bus_mode_e;

    typedef enum logic {
        ASM_IDLE = 1'b0,
        ASM_FILL = 1'b1
    } asm_state_e;

    typedef enum logic {
        SEL_OFF = 1'b0,
        SEL_ON  = 1'b1
    } sel_state_e;

endpackage

// File: rtl/cbtx_store.sv
module cbtx_store
    import cbtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    localparam int DEPTH     = CELL_BYTES * CELLS,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int PART_W    = $clog2(CELL_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              soc,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  held_cnt,
    output logic              cell_ready,
    output logic              overflow,
    output logic              runt_err
);

    logic [DATA_W-1:0] mem [DEPTH];

    asm_state_e       state_q, state_d;
    logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
    logic [PTR_W-1:0] cm_ptr_q, cm_ptr_d;
    logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
    logic [CNT_W-1:0] held_q, held_d;
    logic [CNT_W-1:0] cm_cnt_q, cm_cnt_d;
    logic [PART_W-1:0] part_q, part_d;
    logic             ovf_q, runt_q;

    logic             full;
    logic             wr_fire;
    logic             rd_fire;
    logic             restart;
    logic             commit;
    logic [PTR_W-1:0] slot;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Strobe decode and write slot selection
    always_comb begin
        full    = (held_q == CNT_W'(DEPTH));
        wr_fire = wr_req && !full;
        rd_fire = rd_req && (cm_cnt_q != '0);
        restart = wr_fire && soc && (state_q == ASM_FILL);
        slot    = restart ? cm_ptr_q : wr_ptr_q;
        commit  = wr_fire && !restart && (part_q == PART_W'(CELL_BYTES - 1));
    end

    // Next-state and counter logic
    always_comb begin
        state_d  = state_q;
        part_d   = part_q;
        wr_ptr_d = wr_ptr_q;
        cm_ptr_d = cm_ptr_q;
        rd_ptr_d = rd_fire ? step_ptr(rd_ptr_q) : rd_ptr_q;
        held_d   = held_q - CNT_W'(rd_fire);
        cm_cnt_d = cm_cnt_q - CNT_W'(rd_fire);
        if (wr_fire) begin
            wr_ptr_d = step_ptr(slot);
            held_d   = held_d + 1'b1;
            unique case (state_q)
                ASM_IDLE: begin
                    state_d = ASM_FILL;
                    part_d  = PART_W'(1);
                end
                ASM_FILL: begin
                    if (restart) begin
                        held_d = held_d - CNT_W'(part_q);
                        part_d = PART_W'(1);
                    end else if (commit) begin
                        state_d  = ASM_IDLE;
                        part_d   = '0;
                        cm_ptr_d = step_ptr(slot);
                        cm_cnt_d = cm_cnt_d + CNT_W'(CELL_BYTES);
                    end else begin
                        part_d = part_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ASM_IDLE;
            part_q   <= '0;
            wr_ptr_q <= '0;
            cm_ptr_q <= '0;
            rd_ptr_q <= '0;
            held_q   <= '0;
            cm_cnt_q <= '0;
            ovf_q    <= 1'b0;
            runt_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            part_q   <= part_d;
            wr_ptr_q <= wr_ptr_d;
            cm_ptr_q <= cm_ptr_d;
            rd_ptr_q <= rd_ptr_d;
            held_q   <= held_d;
            cm_cnt_q <= cm_cnt_d;
            ovf_q    <= ovf_q | (wr_req && full);
            runt_q   <= runt_q | restart;
        end
    end

    // Byte storage, no reset
    always_ff @(posedge clk) begin
        if (wr_fire) begin
            mem[slot] <= din;
        end
    end

    // Outputs
    always_comb begin
        rd_data    = mem[rd_ptr_q];
        held_cnt   = held_q;
        cell_ready = (cm_cnt_q >= CNT_W'(CELL_BYTES));
        overflow   = ovf_q;
        runt_err   = runt_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) held_q <= CNT_W'(DEPTH)); // R7
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && wr_req && !rd_req) |=> $stable(held_q)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q); // R7
    AST_RUNT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) runt_q |=> runt_q); // R8
    AST_COMMIT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) cm_cnt_q <= held_q); // R9
    AST_IDLE_NO_PART: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ASM_IDLE) |-> (part_q == '0)); // R8

endmodule

// File: rtl/cbtx_select.sv
module cbtx_select
    import cbtx_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_mphy,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              selected
);

    sel_state_e state_q, state_d;
    logic       hit;

    always_comb begin
        hit = is_mphy && wr_req && (addr == own_addr);
        unique case (state_q)
            SEL_OFF: state_d = hit ? SEL_ON : SEL_OFF;
            SEL_ON:  state_d = hit ? SEL_ON : SEL_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        selected = (state_q == SEL_ON);
    end

    AST_SEL_NEEDS_MPHY: assert property (@(posedge clk) disable iff (!rst_n) !is_mphy |=> !selected); // R6

endmodule

// File: rtl/cbtx_flow.sv
module cbtx_flow
    import cbtx_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    parameter int OCTET_ROOM = 4,
    localparam int DEPTH     = CELL_BYTES * CELLS,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  bus_mode_e        mode,
    input  logic [CNT_W-1:0] held_cnt,
    input  logic             selected,
    output logic             clav,
    output logic             clav_oe
);

    logic [CNT_W-1:0] room;
    logic             room_ok;

    always_comb begin
        room = CNT_W'(DEPTH) - held_cnt;
        unique case (mode)
            MODE_OCTET: begin
                room_ok = (room >= CNT_W'(OCTET_ROOM));
                clav_oe = 1'b1;
            end
            MODE_CELL, MODE_CELL2: begin
                room_ok = (room >= CNT_W'(CELL_BYTES));
                clav_oe = 1'b1;
            end
            MODE_MPHY: begin
                room_ok = (room >= CNT_W'(CELL_BYTES));
                clav_oe = selected;
            end
        endcase
        clav = clav_oe && room_ok;
    end

endmodule

// File: rtl/cell_tx_slave.sv
module cell_tx_slave
    import cbtx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 5,
    parameter int CELL_BYTES = 53,
    parameter int CELLS      = 4,
    parameter int OCTET_ROOM = 4,
    localparam int DEPTH     = CELL_BYTES * CELLS,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_n,
    input  logic              soc,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [1:0]        mode,
    output logic              clav,
    output logic              clav_oe,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              cell_ready,
    output logic              overflow,
    output logic              runt_err
);

    bus_mode_e        mode_e;
    logic             wr_req;
    logic             selected;
    logic [CNT_W-1:0] held_cnt;

    assign mode_e = bus_mode_e'(mode);
    assign wr_req = !wr_n;

    cbtx_store #(
        .DATA_W     (DATA_W),
        .CELL_BYTES (CELL_BYTES),
        .CELLS      (CELLS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .soc        (soc),
        .din        (din),
        .rd_req     (rd_en),
        .rd_data    (rd_data),
        .held_cnt   (held_cnt),
        .cell_ready (cell_ready),
        .overflow   (overflow),
        .runt_err   (runt_err)
    );

    cbtx_select #(
        .ADDR_W (ADDR_W)
    ) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_mphy  (mode_e == MODE_MPHY),
        .wr_req   (wr_req),
        .addr     (addr),
        .own_addr (own_addr),
        .selected (selected)
    );

    cbtx_flow #(
        .CELL_BYTES (CELL_BYTES),
        .CELLS      (CELLS),
        .OCTET_ROOM (OCTET_ROOM)
    ) u_flow (
        .mode     (mode_e),
        .held_cnt (held_cnt),
        .selected (selected),
        .clav     (clav),
        .clav_oe  (clav_oe)
    );

    AST_MATCH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && !wr_n && addr == own_addr) |=> clav_oe); // R5
    AST_MISS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b10 && !(!wr_n && addr == own_addr)) |=> (mode != 2'b10 || !clav_oe)); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n) !clav_oe |-> !clav); // R5
    AST_SINGLE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) (mode != 2'b10) |-> clav_oe); // R6
    AST_OCTET_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (mode == 2'b00 && held_cnt > CNT_W'(DEPTH - OCTET_ROOM)) |-> !clav); // R3
    AST_READY_WHOLE: assert property (@(posedge clk) disable iff (!rst_n) cell_ready |-> held_cnt >= CNT_W'(CELL_BYTES)); // R9

endmodule

// File: tb/cell_tx_slave_tb.sv
module cell_tx_slave_tb;

    localparam int CB    = 53;
    localparam int DEPTH = 212;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       wr_n = 1'b1;
    logic       soc = 1'b0;
    logic [4:0] addr = '0;
    logic [4:0] own_addr = 5'h13;
    logic [1:0] mode = 2'b00;
    logic       rd_en = 1'b0;
    logic       clav, clav_oe, cell_ready, overflow, runt_err;
    logic [7:0] rd_data;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] q_com[$];
    logic [7:0] q_part[$];
    bit m_ovf = 0, m_runt = 0, m_sel = 0;

    always #5 clk = ~clk;

    cell_tx_slave u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_n(wr_n), .soc(soc),
        .addr(addr), .own_addr(own_addr), .mode(mode), .clav(clav),
        .clav_oe(clav_oe), .rd_en(rd_en), .rd_data(rd_data),
        .cell_ready(cell_ready), .overflow(overflow), .runt_err(runt_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // Reference model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            q_com.delete();
            q_part.delete();
            m_ovf  = 0;
            m_runt = 0;
            m_sel  = 0;
        end else begin
            int held;
            bit rf;
            held = q_com.size() + q_part.size();
            rf   = rd_en && (q_com.size() > 0);
            if (!wr_n) begin
                if (held == DEPTH) begin
                    m_ovf = 1;
                end else if (soc && q_part.size() > 0) begin
                    m_runt = 1;
                    q_part.delete();
                    q_part.push_back(din);
                end else begin
                    q_part.push_back(din);
                    if (q_part.size() == CB) begin
                        foreach (q_part[k]) q_com.push_back(q_part[k]);
                        q_part.delete();
                    end
                end
            end
            if (rf) void'(q_com.pop_front());
            m_sel = (mode == 2'b10) && (addr == own_addr) && !wr_n;
        end
    end

    // Comparison on every falling edge
    always @(negedge clk) begin
        int room;
        bit oe_exp;
        int thr;
        room   = DEPTH - (q_com.size() + q_part.size());
        oe_exp = (mode != 2'b10) || m_sel;
        thr    = (mode == 2'b00) ? 4 : CB;
        if (mode == 2'b10) begin
            chk("R5 clav_oe", clav_oe, oe_exp);
            chk("R5 clav", clav, oe_exp && room >= thr);
        end else begin
            chk("R6 clav_oe", clav_oe, 1);
            case (mode)
                2'b00: chk("R3 clav", clav, room >= thr);
                2'b01: chk("R4 clav", clav, room >= thr);
                default: chk("R10 clav", clav, room >= thr);
            endcase
        end
        chk("R9 cell_ready", cell_ready, q_com.size() >= CB);
        chk("R7 overflow", overflow, m_ovf);
        chk("R8 runt_err", runt_err, m_runt);
        if (q_com.size() > 0) chk("R2 rd_data", rd_data, q_com[0]);
    end

    task automatic cyc(input logic wn, input logic [7:0] d, input logic s, input logic re);
        wr_n  = wn;
        din   = d;
        soc   = s;
        rd_en = re;
        @(posedge clk);
        #2;
    endtask

    task automatic put_cell(input logic [7:0] base, input logic re);
        for (int i = 0; i < CB; i++) cyc(1'b0, base + 8'(i), i == 0, re);
    endtask

    task automatic idle_read(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 8'h00, 1'b0, 1'b1);
    endtask

    initial begin
        mode = 2'b10;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state seen at the ports
        chk("R1 clav_oe", clav_oe, 0);
        chk("R1 cell_ready", cell_ready, 0);
        chk("R1 overflow", overflow, 0);
        chk("R1 runt_err", runt_err, 0);
        #1;
        rst_n = 1'b1;
        mode  = 2'b00;
        #1;
        chk("R1 clav", clav, 1);
        @(posedge clk);
        #2;

        // Octet mode: whole cells, partial drain (R2, R3, R9)
        put_cell(8'h10, 1'b0);
        put_cell(8'h60, 1'b0);
        idle_read(30);
        // Overfill past 212 bytes (R7), then drain (R2, R9)
        put_cell(8'hA0, 1'b0);
        put_cell(8'h20, 1'b0);
        put_cell(8'hC0, 1'b0);
        for (int i = 0; i < 8; i++) cyc(1'b0, 8'hEE, 1'b0, 1'b0);
        idle_read(250);

        // Cell mode: runt then refill (R4, R8)
        mode = 2'b01;
        for (int i = 0; i < 10; i++) cyc(1'b0, 8'h30 + 8'(i), i == 0, 1'b0);
        put_cell(8'h40, 1'b0);
        for (int i = 0; i < 20; i++) cyc(1'b0, 8'h70 + 8'(i), i == 0, 1'b0);
        put_cell(8'h80, 1'b0);
        put_cell(8'h90, 1'b0);
        put_cell(8'hB0, 1'b0);
        for (int i = 0; i < 300; i++) cyc(i[1:0] == 2'b11, 8'(i), (i % 53) == 0, 1'b1);

        // Multi-PHY: match with and without strobe (R5)
        mode = 2'b10;
        own_addr = 5'h13;
        addr = 5'h13;
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) cyc(1'b0, 8'h50 + 8'(i), i == 0, 1'b0);
        addr = 5'h05;
        cyc(1'b0, 8'h55, 1'b0, 1'b0);
        cyc(1'b1, 8'h00, 1'b0, 1'b0);
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a);
            cyc(1'b0, 8'(a), 1'b0, 1'b0);
            cyc(1'b1, 8'h00, 1'b0, 1'b0);
        end
        own_addr = 5'h00;
        addr = 5'h00;
        for (int i = 0; i < 200; i++) cyc(1'b0, 8'(i), (i % 53) == 0, i[0]);
        addr = 5'h1F;
        idle_read(40);

        // Octet mode with random address traffic (R6, R3)
        mode = 2'b00;
        for (int i = 0; i < 400; i++) begin
            addr = 5'($urandom_range(0, 31));
            cyc(($urandom_range(0, 3) == 0), 8'($urandom_range(0, 255)),
                ($urandom_range(0, 40) == 0), ($urandom_range(0, 2) == 0));
        end
        // Alternate cell encoding with random soc (R10, R8)
        mode = 2'b11;
        for (int i = 0; i < 600; i++) begin
            addr = 5'($urandom_range(0, 31));
            cyc(($urandom_range(0, 2) == 0), 8'($urandom_range(0, 255)),
                ($urandom_range(0, 60) == 0), ($urandom_range(0, 1) == 0));
        end
        idle_read(250);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule